// File: doc/BRIEF.md
# Peripheral Interrupt Aggregation Controller

This block collects sixty-four peripheral interrupt request levels and funnels them onto a small set of general-purpose core interrupt lines. Every source owns one bit in each of three per-source registers: an enable (mask) bit, a read-only level bit that reports whether the source is asserting, and a wakeup-enable bit. The sources are split into a low bank of 32 and a high bank of 32. Each core line is the OR of the enabled sources routed to it by a fixed rule: source s feeds line s mod NIRQ.

A two-stage detector watches every core line for rising edges. Each detected edge sets a pending-latch bit. When the core takes the event, it pulses an acknowledge carrying the line number. That acknowledge moves the event from the pending latch into the in-service register, and from then on a fresh edge on the line is queued again. A return strobe carrying the line number retires the event from the in-service register. While the core is powered down, a combinational wakeup output reports any asserted source that has its wakeup-enable bit set.

Top module: `pic_aggregator`

## Requirements
- R1: A set enable bit lets its source drive its core line. A cleared enable bit keeps the source from ever setting a pending bit. All enable bits are 0 after reset.
- R2: Reading address 2 returns the raw levels of sources 0..31 (bit i is source i), and address 3 returns sources 32..63. Both reads ignore the enable and wakeup bits.
- R3: With `reg_we` high, a write stores `reg_wdata` on the clock edge. Address 0 holds the enable bits of sources 0..31 and address 1 holds those of sources 32..63. Address 4 holds the wakeup-enable bits of sources 0..31 and address 5 holds those of sources 32..63. Reads of these addresses return the stored value. Addresses 2, 3, 6 and 7 ignore writes, and addresses 6 and 7 read 0.
- R4: `wakeup` is 1 exactly when `core_sleep` is 1 and some source is asserted with its wakeup-enable bit set, whatever its enable bit.
- R5: Core line n is the OR of the enabled sources s with s mod NIRQ = n. Suppose that OR turns 1 before clock edge k, having been 0 before edge k-1. Then `pend_latch[n]` reads 1 after edge k+1 and not before.
- R6: A set pending bit stays set, and further edges on its line have no effect, until that line is acknowledged.
- R7: An acknowledge (`ack_valid` with `ack_id` = n) on an edge where `pend_latch[n]` is 1 sets `in_service[n]` and clears `pend_latch[n]` on that same edge. An acknowledge of a line whose pending bit is 0 changes nothing.
- R8: A rising edge detected on the acknowledge edge or later sets `pend_latch[n]` again, even while `in_service[n]` is 1.
- R9: A return (`ret_valid` with `ret_id` = n) clears `in_service[n]`. If an accepted acknowledge of the same line falls on the same edge, the acknowledge wins and the bit stays 1.
- R10: The shortest path from a line's OR turning 1 (before edge k) to `in_service` turning 1 takes three edges: an acknowledge on edge k+2 is accepted.
- R11: While `rst_n` is 0, every register is cleared on each clock edge: enables, wakeup enables, detector stages, pending bits and in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | 64 | Peripheral request levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ack_valid | input | 1 | Core acknowledges an event |
| ack_id | input | IDW | Line being acknowledged |
| ret_valid | input | 1 | Core returns from an event |
| ret_id | input | IDW | Line being retired |
| core_sleep | input | 1 | Core is in a powered-down mode |
| pend_latch | output | NIRQ | Pending edge latch per core line |
| in_service | output | NIRQ | Active or nested events per core line |
| wakeup | output | 1 | Wake request while sleeping |

## Verification
The assertions assume that every input changes synchronously to `clk`. They also assume that `ack_id` and `ret_id` name a line below NIRQ whenever their valid strobe is high. The stimulus drives every input just after the falling edge and draws identifiers only from 0..NIRQ-1. An acknowledge aimed at a line with no pending bit is treated as legal input that the block must ignore, so the random phase issues such acknowledges on purpose.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int BANK_W = 32;
  localparam int NBANK  = 2;
  localparam int NSRC   = BANK_W * NBANK;

  typedef enum logic [2:0] {
    ADR_EN_LO   = 3'd0,
    ADR_EN_HI   = 3'd1,
    ADR_LVL_LO  = 3'd2,
    ADR_LVL_HI  = 3'd3,
    ADR_WAKE_LO = 3'd4,
    ADR_WAKE_HI = 3'd5
  } pic_addr_e;

  // fixed routing rule: which core line a source feeds
  function automatic int line_of(input int src, input int nirq);
    return src % nirq;
  endfunction

  // does register address select bank b of the given base
  function automatic logic addr_hits(input logic [2:0] a, input logic [2:0] base, input int b);
    return a == (base + 3'(b));
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [BANK_W-1:0] wdata,
  input  logic [NSRC-1:0]   src,
  output logic [NSRC-1:0]   en_bits,
  output logic [NSRC-1:0]   wake_bits,
  output logic [BANK_W-1:0] rdata
);
  logic [BANK_W-1:0] rd_bank [3*NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_bits[b*BANK_W +: BANK_W]   <= '0;
        wake_bits[b*BANK_W +: BANK_W] <= '0;
      end else if (we) begin
        if (addr_hits(addr, ADR_EN_LO, b))   en_bits[b*BANK_W +: BANK_W]   <= wdata;
        if (addr_hits(addr, ADR_WAKE_LO, b)) wake_bits[b*BANK_W +: BANK_W] <= wdata;
      end
    end
    assign rd_bank[b]           = en_bits[b*BANK_W +: BANK_W];
    assign rd_bank[NBANK+b]     = src[b*BANK_W +: BANK_W];
    assign rd_bank[2*NBANK+b]   = wake_bits[b*BANK_W +: BANK_W];
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < 3*NBANK; i++)
      if (addr == 3'(i)) rdata = rd_bank[i];
  end
endmodule

// File: rtl/pic_route.sv
module pic_route
  import pic_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] en_bits,
  output logic [NIRQ-1:0] line
);
  logic [NSRC-1:0] live;
  assign live = src & en_bits;

  for (genvar n = 0; n < NIRQ; n++) begin : g_line
    always_comb begin
      line[n] = 1'b0;
      for (int s = 0; s < NSRC; s++)
        if (line_of(s, NIRQ) == n) line[n] = line[n] | live[s];
    end
  end
endmodule

// File: rtl/pic_edge_line.sv
module pic_edge_line (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic ack_sel,
  input  logic ret_sel,
  output logic pend,
  output logic busy,
  output logic rise,
  output logic take
);
  logic stage1, stage2;

  assign rise = stage1 & ~stage2;
  assign take = ack_sel & pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      stage2 <= 1'b0;
      pend   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      stage1 <= line_in;
      stage2 <= stage1;
      pend   <= (pend & ~take) | rise;
      busy   <= take | (busy & ~ret_sel);
    end
  end
endmodule

// File: rtl/pic_aggregator.sv
module pic_aggregator
  import pic_pkg::*;
#(
  parameter int NIRQ = 8,
  localparam int IDW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  input  logic              ack_valid,
  input  logic [IDW-1:0]    ack_id,
  input  logic              ret_valid,
  input  logic [IDW-1:0]    ret_id,
  input  logic              core_sleep,
  output logic [NIRQ-1:0]   pend_latch,
  output logic [NIRQ-1:0]   in_service,
  output logic              wakeup
);
  logic [NSRC-1:0] en_bits, wake_bits;
  logic [NIRQ-1:0] core_line, rise_vec, ack_take, ack_sel, ret_sel;

  pic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .src(src_req), .en_bits(en_bits), .wake_bits(wake_bits), .rdata(reg_rdata)
  );

  pic_route #(.NIRQ(NIRQ)) u_route (
    .src(src_req), .en_bits(en_bits), .line(core_line)
  );

  for (genvar n = 0; n < NIRQ; n++) begin : g_evt
    assign ack_sel[n] = ack_valid & (ack_id == IDW'(n));
    assign ret_sel[n] = ret_valid & (ret_id == IDW'(n));
    pic_edge_line u_line (
      .clk(clk), .rst_n(rst_n), .line_in(core_line[n]),
      .ack_sel(ack_sel[n]), .ret_sel(ret_sel[n]),
      .pend(pend_latch[n]), .busy(in_service[n]),
      .rise(rise_vec[n]), .take(ack_take[n])
    );
  end

  assign wakeup = core_sleep & |(src_req & wake_bits);
endmodule

// File: rtl/pic_aggregator_chk.sv
module pic_aggregator_chk #(
  parameter int NIRQ = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_sleep,
  input logic            wakeup,
  input logic [NIRQ-1:0] pend_latch,
  input logic [NIRQ-1:0] in_service,
  input logic [NIRQ-1:0] rise_vec,
  input logic [NIRQ-1:0] ack_take,
  input logic [NIRQ-1:0] ret_sel
);
  // R4
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |-> core_sleep);

  // R5
  pend_set_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_latch & ~$past(pend_latch) & ~$past(rise_vec)) == '0));

  // R6
  pend_clears_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_latch) & ~pend_latch & ~$past(ack_take)) == '0));

  // R7
  ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_take) |=> ((in_service & $past(ack_take)) == $past(ack_take)));

  // R10
  service_only_by_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_service & ~$past(in_service) & ~$past(ack_take)) == '0));

  // R9
  return_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ret_sel & ~ack_take)) |=> ((in_service & $past(ret_sel & ~ack_take)) == '0));
endmodule

bind pic_aggregator pic_aggregator_chk #(.NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_sleep(core_sleep), .wakeup(wakeup),
  .pend_latch(pend_latch), .in_service(in_service),
  .rise_vec(rise_vec), .ack_take(ack_take), .ret_sel(ret_sel)
);

// File: tb/test_pic_aggregator.sv
module test_pic_aggregator;
  localparam int PERIOD = 10;
  localparam int NIRQ = 8;
  localparam int IDW = 3;
  localparam int NS = 64;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src_req = '0;
  logic reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ack_valid = 0, ret_valid = 0, core_sleep = 0;
  logic [IDW-1:0] ack_id = '0, ret_id = '0;
  logic [NIRQ-1:0] pend_latch, in_service;
  logic wakeup;

  int checks = 0, fails = 0;

  // reference state
  bit m_en [NS];
  bit m_wk [NS];
  bit m_s1 [NIRQ], m_s2 [NIRQ], m_pend [NIRQ], m_busy [NIRQ];

  pic_aggregator #(.NIRQ(NIRQ)) i_pic_aggregator (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid), .ack_id(ack_id),
    .ret_valid(ret_valid), .ret_id(ret_id), .core_sleep(core_sleep),
    .pend_latch(pend_latch), .in_service(in_service), .wakeup(wakeup)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_line(int n);
    bit r = 0;
    for (int s = 0; s < NS; s++)
      if ((s % NIRQ) == n && src_req[s] && m_en[s]) r = 1;
    return r;
  endfunction

  function automatic logic [31:0] model_read(logic [2:0] a);
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) begin
      case (a)
        3'd0: v[i] = m_en[i];
        3'd1: v[i] = m_en[32+i];
        3'd2: v[i] = src_req[i];
        3'd3: v[i] = src_req[32+i];
        3'd4: v[i] = m_wk[i];
        3'd5: v[i] = m_wk[32+i];
        default: v[i] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic model_edge();
    bit ln [NIRQ];
    bit rs, tk;
    for (int n = 0; n < NIRQ; n++) ln[n] = model_line(n);
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin m_en[s] = 0; m_wk[s] = 0; end
      for (int n = 0; n < NIRQ; n++) begin m_s1[n]=0; m_s2[n]=0; m_pend[n]=0; m_busy[n]=0; end
      return;
    end
    for (int n = 0; n < NIRQ; n++) begin
      rs = m_s1[n] && !m_s2[n];
      tk = ack_valid && (int'(ack_id) == n) && m_pend[n];
      if (ret_valid && int'(ret_id) == n) m_busy[n] = 0;
      if (tk) begin m_busy[n] = 1; m_pend[n] = 0; end
      if (rs) m_pend[n] = 1;
      m_s2[n] = m_s1[n];
      m_s1[n] = ln[n];
    end
    if (reg_we)
      for (int i = 0; i < 32; i++) begin
        if (reg_addr == 3'd0) m_en[i] = reg_wdata[i];
        if (reg_addr == 3'd1) m_en[32+i] = reg_wdata[i];
        if (reg_addr == 3'd4) m_wk[i] = reg_wdata[i];
        if (reg_addr == 3'd5) m_wk[32+i] = reg_wdata[i];
      end
  endtask

  task automatic compare_all();
    logic [NIRQ-1:0] ep, eb;
    bit ew = 0;
    for (int n = 0; n < NIRQ; n++) begin ep[n] = m_pend[n]; eb[n] = m_busy[n]; end
    for (int s = 0; s < NS; s++) if (src_req[s] && m_wk[s]) ew = core_sleep;
    chk("R5/R6 pend_latch", pend_latch, ep);
    chk("R7/R9 in_service", in_service, eb);
    chk("R4 wakeup", wakeup, ew);
    chk("R2/R3 reg_rdata", reg_rdata, model_read(reg_addr));
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    reg_we = 0; ack_valid = 0; ret_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 0;
  endtask

  initial begin
    #(PERIOD*150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0;
    cyc(); cyc();
    // R11 reset state
    chk("R11 pend after reset", pend_latch, 0);
    chk("R11 in_service after reset", in_service, 0);
    reg_addr = 3'd0; #1;
    chk("R11 enable after reset", reg_rdata, 0);
    rst_n = 1;
    cyc();

    // R3 register write/readback and ignored addresses
    wr(3'd0, 32'h0000_0101);
    wr(3'd1, 32'h0000_0002);
    wr(3'd4, 32'h8000_0000);
    wr(3'd6, 32'hFFFF_FFFF);
    reg_addr = 3'd6; #1;
    chk("R3 unused address reads 0", reg_rdata, 0);
    reg_addr = 3'd1; #1;
    chk("R3 high enable readback", reg_rdata, 32'h2);

    // R5 timing: source 0 -> line 0
    src_req[0] = 1;
    cyc();
    chk("R5 pend not yet after one edge", pend_latch[0], 0);
    cyc();
    chk("R5 pend set after two edges", pend_latch[0], 1);
    // R10 acknowledge on the third edge
    ack_valid = 1; ack_id = 0;
    cyc(); idle();
    chk("R10 in_service at minimum latency", in_service[0], 1);
    chk("R7 pend cleared by ack", pend_latch[0], 0);

    // R8 re-queue while in service (source 8 also on line 0)
    src_req[0] = 0; cyc(); cyc();
    src_req[8] = 1; cyc(); cyc();
    chk("R8 new edge queued while in service", pend_latch[0], 1);
    // R6 more edges no effect
    src_req[8] = 0; cyc(); src_req[8] = 1; cyc(); cyc();
    chk("R6 pend held", pend_latch[0], 1);
    // R9 return with simultaneous ack: ack wins
    ack_valid = 1; ack_id = 0; ret_valid = 1; ret_id = 0;
    cyc(); idle();
    chk("R9 ack wins over return", in_service[0], 1);
    ret_valid = 1; ret_id = 0;
    cyc(); idle();
    chk("R9 return clears", in_service[0], 0);
    // R7 ack of empty line ignored
    ack_valid = 1; ack_id = 3;
    cyc(); idle();
    chk("R7 ack without pend ignored", in_service[3], 0);

    // R1 masked source: 16 on line 0, disabled
    src_req = '0; cyc(); cyc(); cyc();
    src_req[16] = 1; cyc(); cyc(); cyc();
    chk("R1 masked source no pend", pend_latch[0], 0);
    // R5 high bank: source 33 on line 1
    src_req[33] = 1; cyc(); cyc();
    chk("R5 high bank routes to line 1", pend_latch[1], 1);
    // R2 level read ignores enable
    reg_addr = 3'd2; #1;
    chk("R2 low level read", reg_rdata, 32'h0001_0000);
    // R4 wakeup on source 31, independent of enable
    src_req[31] = 1; core_sleep = 0; #1;
    chk("R4 no wakeup while awake", wakeup, 0);
    core_sleep = 1; #1;
    chk("R4 wakeup while sleeping", wakeup, 1);

    // random phase with per-cycle model comparison
    for (int t = 0; t < 4000; t++) begin
      if ($urandom_range(0, 3) == 0) src_req[$urandom_range(0, NS-1)] ^= 1'b1;
      reg_we = ($urandom_range(0, 19) == 0);
      reg_addr = 3'($urandom_range(0, 7));
      reg_wdata = $urandom;
      ack_valid = ($urandom_range(0, 2) == 0);
      ack_id = IDW'($urandom_range(0, NIRQ-1));
      ret_valid = ($urandom_range(0, 4) == 0);
      ret_id = IDW'($urandom_range(0, NIRQ-1));
      core_sleep = $urandom_range(0, 1);
      cyc();
    end
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule